// File: doc/BRIEF.md
# USB bus event interrupt controller

This block watches the two data lines of a full-speed USB bus and turns four bus-wide conditions into sticky event flags: a long single-ended zero (bus reset), a long quiet spell (suspend), a short single-ended zero closed by an idle J (end of packet), and any line change while suspended (resume). Each flag drives a shared interrupt request when its enable bit is set. A clock-enable output for the serial engine drops when the bus suspends. It comes back only when software acknowledges the suspend after the bus has woken up. The lines are sampled in the block's own clock domain through a two-flop synchroniser. Both time thresholds count whole milliseconds derived from a clock-frequency parameter.

Two state machines do the work. The line classifier has four states. `SE_IDLE` moves to `SE_SHORT` on the first SE0 sample, or straight to `SE_EOP` when one sample already covers a bit time. `SE_SHORT` moves to `SE_EOP` once the SE0 has lasted a bit time, and back to `SE_IDLE` on any other line state. `SE_SHORT` and `SE_EOP` move to `SE_RST` when the reset timer expires. `SE_EOP` returns to `SE_IDLE` on any non-SE0 state and reports an end of packet if that state is J. `SE_RST` returns to `SE_IDLE` when the SE0 ends.

The power machine has three states. `PW_ACTIVE` moves to `PW_SUSPEND` when the idle timer expires. `PW_SUSPEND` moves to `PW_WAKE` on any line change. `PW_WAKE` moves to `PW_ACTIVE` when software writes 1 to the suspend flag. Software reaches two 8-bit registers through a one-bit address.

Top module: `usb_bus_evt_ctrl`

## Requirements
- R1: SE0 held for at least RESET_MS milliseconds sets the bus-reset flag (bit 3 of the flag register). A shorter SE0 does not set it.
- R2: A bus reset leaves the enable register, the other flags and the serial-engine clock enable unchanged.
- R3: When the line stays in one non-SE0 state with no change for SUSPEND_MS milliseconds, the suspend flag (bit 2) is set and `sie_clk_en_o` drops to 0. Any line change or SE0 restarts the idle count.
- R4: An SE0 lasting at least BIT_CYCLES clock samples and then followed by J (D+ high, D- low) sets the end-of-packet flag (bit 1). A shorter SE0 sets nothing.
- R5: Any line change while suspended sets the resume flag (bit 0).
- R6: `sie_clk_en_o` is 1 after reset. Once suspended, it returns to 1 only on a write of 1 to flag bit 2 made after the resume. The same write made while still suspended leaves the clock enable at 0.
- R7: Address 0 is the enable register and address 1 is the flag register. Both reset to 0x00. Enable bits 3, 2, 1 and 0 gate bus reset, suspend, end of packet and resume. Bits 7 to 4 of either register read as 0.
- R8: `irq_o` is 1 exactly when some flag bit and the enable bit in the same position are both 1.
- R9: An SE0 long enough to count as a bus reset does not also set the end-of-packet flag when it ends.
- R10: A flag bit clears only when 1 is written to that bit at address 1. Writing 0 has no effect. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable register, 1 = flag register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| sie_clk_en_o | output | 1 | Clock enable for the serial engine |

## Verification
The bench targets the edges of the SE0 classifier. A one-sample glitch must report nothing, where a design that counted any SE0 as an end of packet would set bit 1. An SE0 just short of the reset time must give an end of packet and no reset, where a design with a miscounted timer would set the wrong flag. An SE0 well past the reset time must give a reset and no end of packet, where a design that ignored R9 would set both. The bench also clears the suspend flag before the resume and then checks that the clock enable stays off; a design that re-enabled the clock on any clear would turn it on too early. Random enable values and clear masks are checked against a bench model of the sticky flags and the interrupt, which catches swapped bit positions and write-0 clears.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
    // line state as {D+, D-}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    localparam int NUM_EVT = 4;
    localparam int DW      = 8;
    localparam int FLG_RES = 0;
    localparam int FLG_EOP = 1;
    localparam int FLG_SUS = 2;
    localparam int FLG_RST = 3;

    localparam logic ADDR_EN  = 1'b0;
    localparam logic ADDR_FLG = 1'b1;
endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync
    import usb_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp_i,
    input  logic  dm_i,
    output line_e line_o,
    output logic  chg_o
);
    logic [1:0] meta_q;
    logic [1:0] sync_q;
    logic [1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= LN_J;
            sync_q <= LN_J;
            prev_q <= LN_J;
        end else begin
            meta_q <= {dp_i, dm_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_o = line_e'(sync_q);
    assign chg_o  = (sync_q != prev_q);
endmodule

// File: rtl/usb_ms_timer.sv
module usb_ms_timer #(
    parameter int CYC_PER_MS = 48000,
    parameter int LIMIT_MS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic hit_o
);
    localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int MW = $clog2(LIMIT_MS + 1);

    logic [CW-1:0] cyc_q;
    logic [MW-1:0] ms_q;

    assign hit_o = (ms_q == MW'(LIMIT_MS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (clr_i) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (!hit_o) begin
            if (cyc_q == CW'(CYC_PER_MS - 1)) begin
                cyc_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_se0_fsm.sv
module usb_se0_fsm
    import usb_evt_pkg::*;
#(
    parameter int BIT_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_e line_i,
    input  logic  rst_hit_i,
    output logic  eop_evt_o,
    output logic  rst_evt_o
);
    localparam int BW = $clog2(BIT_CYCLES + 2);

    typedef enum logic [1:0] {SE_IDLE, SE_SHORT, SE_EOP, SE_RST} se_st_e;

    se_st_e        st_q, st_d;
    logic [BW-1:0] cnt_q;
    logic          is_se0;

    assign is_se0 = (line_i == LN_SE0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SE_IDLE;
            cnt_q <= BW'(1);
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == SE_SHORT) ? cnt_q + 1'b1 : BW'(1);
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SE_IDLE:  if (is_se0) st_d = (BIT_CYCLES <= 1) ? SE_EOP : SE_SHORT;
            SE_SHORT: begin
                if (!is_se0)                            st_d = SE_IDLE;
                else if (rst_hit_i)                     st_d = SE_RST;
                else if (int'(cnt_q) + 1 >= BIT_CYCLES) st_d = SE_EOP;
            end
            SE_EOP: begin
                if (!is_se0)        st_d = SE_IDLE;
                else if (rst_hit_i) st_d = SE_RST;
            end
            SE_RST:   if (!is_se0) st_d = SE_IDLE;
            default:  st_d = SE_IDLE;
        endcase
    end

    always_comb begin
        eop_evt_o = 1'b0;
        rst_evt_o = 1'b0;
        unique case (st_q)
            SE_SHORT: rst_evt_o = is_se0 && rst_hit_i;
            SE_EOP: begin
                rst_evt_o = is_se0 && rst_hit_i;
                eop_evt_o = (line_i == LN_J);
            end
            SE_IDLE, SE_RST: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/usb_pwr_fsm.sv
module usb_pwr_fsm
    import usb_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_e line_i,
    input  logic  chg_i,
    input  logic  idle_hit_i,
    input  logic  susp_clr_i,
    output logic  idle_clr_o,
    output logic  susp_evt_o,
    output logic  res_evt_o,
    output logic  clk_en_o
);
    typedef enum logic [1:0] {PW_ACTIVE, PW_SUSPEND, PW_WAKE} pw_st_e;

    pw_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PW_ACTIVE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PW_ACTIVE:  if (idle_hit_i) st_d = PW_SUSPEND;
            PW_SUSPEND: if (chg_i)      st_d = PW_WAKE;
            PW_WAKE:    if (susp_clr_i) st_d = PW_ACTIVE;
            default:    st_d = PW_ACTIVE;
        endcase
    end

    always_comb begin
        susp_evt_o = 1'b0;
        res_evt_o  = 1'b0;
        clk_en_o   = 1'b0;
        idle_clr_o = 1'b1;
        unique case (st_q)
            PW_ACTIVE: begin
                clk_en_o   = 1'b1;
                susp_evt_o = idle_hit_i;
                idle_clr_o = chg_i || (line_i == LN_SE0);
            end
            PW_SUSPEND: res_evt_o = chg_i;
            PW_WAKE:    ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/usb_bus_evt_ctrl.sv
module usb_bus_evt_ctrl
    import usb_evt_pkg::*;
#(
    parameter int CLK_HZ     = 48_000_000,
    parameter int RESET_MS   = 10,
    parameter int SUSPEND_MS = 3,
    parameter int BIT_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dp_i,
    input  logic          dm_i,
    input  logic          reg_wr_en,
    input  logic          reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o,
    output logic          sie_clk_en_o
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;

    line_e              line;
    logic               chg, rst_hit, idle_hit, idle_clr;
    logic               eop_evt, rst_evt, susp_evt, res_evt;
    logic [NUM_EVT-1:0] en_q, flag_q, set_v, clr_v;
    logic               unused_wbits;

    usb_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .dp_i(dp_i), .dm_i(dm_i),
        .line_o(line), .chg_o(chg)
    );

    usb_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .LIMIT_MS(RESET_MS)) u_rst_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(line != LN_SE0), .hit_o(rst_hit)
    );

    usb_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .LIMIT_MS(SUSPEND_MS)) u_idle_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(idle_clr), .hit_o(idle_hit)
    );

    usb_se0_fsm #(.BIT_CYCLES(BIT_CYCLES)) u_se0 (
        .clk(clk), .rst_n(rst_n), .line_i(line), .rst_hit_i(rst_hit),
        .eop_evt_o(eop_evt), .rst_evt_o(rst_evt)
    );

    usb_pwr_fsm u_pwr (
        .clk(clk), .rst_n(rst_n), .line_i(line), .chg_i(chg),
        .idle_hit_i(idle_hit), .susp_clr_i(clr_v[FLG_SUS]),
        .idle_clr_o(idle_clr), .susp_evt_o(susp_evt), .res_evt_o(res_evt),
        .clk_en_o(sie_clk_en_o)
    );

    always_comb begin
        set_v          = '0;
        set_v[FLG_RES] = res_evt;
        set_v[FLG_EOP] = eop_evt;
        set_v[FLG_SUS] = susp_evt;
        set_v[FLG_RST] = rst_evt;
    end

    assign clr_v = (reg_wr_en && reg_addr == ADDR_FLG) ? reg_wdata[NUM_EVT-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (reg_wr_en && reg_addr == ADDR_EN) en_q <= reg_wdata[NUM_EVT-1:0];
            flag_q <= (flag_q & ~clr_v) | set_v;
        end
    end

    assign unused_wbits = ^reg_wdata[DW-1:NUM_EVT];
    assign reg_rdata    = {{(DW-NUM_EVT){1'b0}}, (reg_addr == ADDR_EN) ? en_q : flag_q};
    assign irq_o        = |(flag_q & en_q);
endmodule

// File: rtl/usb_bus_evt_ctrl_chk.sv
module usb_bus_evt_ctrl_chk
    import usb_evt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic               reg_addr,
    input logic [DW-1:0]      reg_wdata,
    input logic [DW-1:0]      reg_rdata,
    input logic               irq_o,
    input logic               sie_clk_en_o,
    input logic [NUM_EVT-1:0] en_q,
    input logic [NUM_EVT-1:0] flag_q
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:NUM_EVT] == '0); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(reg_wr_en) && $past(reg_addr) == ADDR_FLG)
        |-> ((flag_q & $past(flag_q)) == $past(flag_q))); // R10

    AST_CLK_ON_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sie_clk_en_o)
        |-> $past(reg_wr_en && reg_addr == ADDR_FLG && reg_wdata[FLG_SUS])); // R6

    AST_SUSP_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[FLG_SUS]) |-> !sie_clk_en_o); // R3

    AST_RST_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q[FLG_RST]) && !$past(reg_wr_en))
        |-> ($stable(en_q) && $stable(sie_clk_en_o))); // R2
endmodule

bind usb_bus_evt_ctrl usb_bus_evt_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
    .sie_clk_en_o(sie_clk_en_o), .en_q(en_q), .flag_q(flag_q)
);

// File: tb/usb_bus_evt_ctrl_tb_top.sv
module usb_bus_evt_ctrl_tb_top;
    // 16 cycles per ms: reset after 160 cycles of SE0, suspend after 48 idle cycles
    localparam int CLK_HZ = 16000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b1, dm = 1'b0;
    logic       reg_wr_en = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_o, sie_clk_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    usb_bus_evt_ctrl #(.CLK_HZ(CLK_HZ), .RESET_MS(10), .SUSPEND_MS(3), .BIT_CYCLES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .sie_clk_en_o(sie_clk_en_o)
    );

    function automatic logic [3:0] model_w1c(input logic [3:0] f, input logic [7:0] m);
        return f & ~m[3:0];
    endfunction

    function automatic logic model_irq(input logic [3:0] f, input logic [7:0] e);
        return |(f & e[3:0]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic p, input logic m, input int n);
        dp = p; dm = m;
        cyc(n);
    endtask

    task automatic kick();
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b0, 1);
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [3:0] exp_f;
        void'($urandom(32'd1234));
        cyc(5);
        rst_n = 1'b1;
        cyc(1);

        // R7 reset values, R8 idle request, R6 clock on
        rd_reg(1'b0, rd); chk("R7 enable reset", rd, 8'h00);
        rd_reg(1'b1, rd); chk("R7 flag reset", rd, 8'h00);
        chk("R8 irq after reset", irq_o, 1'b0);
        chk("R6 clk_en after reset", sie_clk_en_o, 1'b1);

        wr_reg(1'b0, 8'hFF);
        rd_reg(1'b0, rd); chk("R7 reserved bits read zero", rd, 8'h0F);
        chk("R8 no flags no irq", irq_o, 1'b0);
        kick();

        // R4 one-sample SE0 glitch
        drive(1'b0, 1'b0, 1); drive(1'b1, 1'b0, 6);
        rd_reg(1'b1, rd); chk("R4 glitch gives no EOP", rd, 8'h00);

        // R4 proper end of packet
        drive(1'b0, 1'b0, 6); drive(1'b1, 1'b0, 6);
        rd_reg(1'b1, rd); chk("R4 EOP flag", rd, 8'h02);
        chk("R8 irq with EOP enabled", irq_o, 1'b1);
        wr_reg(1'b0, 8'h0D);
        chk("R8 irq masked", irq_o, 1'b0);

        // R10 write 0 then write 1
        wr_reg(1'b1, 8'h00);
        rd_reg(1'b1, rd); chk("R10 write zero keeps flag", rd, 8'h02);
        wr_reg(1'b1, 8'h02);
        rd_reg(1'b1, rd); chk("R10 write one clears", rd, 8'h00);

        // R1 SE0 shorter than reset time: EOP only
        drive(1'b0, 1'b0, 120); drive(1'b1, 1'b0, 6);
        rd_reg(1'b1, rd); chk("R1 short SE0 no reset", rd, 8'h02);
        wr_reg(1'b1, 8'h02);

        // R1/R9/R2 long SE0
        wr_reg(1'b0, 8'h05);
        drive(1'b0, 1'b0, 200); drive(1'b1, 1'b0, 6);
        rd_reg(1'b1, rd); chk("R1 R9 reset flag without EOP", rd, 8'h08);
        rd_reg(1'b0, rd); chk("R2 enable kept over bus reset", rd, 8'h05);
        chk("R2 clk_en kept over bus reset", sie_clk_en_o, 1'b1);
        drive(1'b0, 1'b0, 6); drive(1'b1, 1'b0, 4);
        drive(1'b0, 1'b0, 200); drive(1'b1, 1'b0, 6);
        rd_reg(1'b1, rd); chk("R2 flags kept over bus reset", rd, 8'h0A);

        // R3 suspend
        wr_reg(1'b1, 8'h0F);
        kick();
        cyc(80);
        rd_reg(1'b1, rd); chk("R3 suspend flag", rd, 8'h04);
        chk("R3 clk_en off", sie_clk_en_o, 1'b0);
        chk("R8 irq on suspend", irq_o, 1'b1);

        // R6 early ack ignored
        wr_reg(1'b1, 8'h04);
        cyc(3);
        chk("R6 ack before resume keeps clock off", sie_clk_en_o, 1'b0);

        // R5 resume
        drive(1'b0, 1'b1, 2); drive(1'b1, 1'b0, 4);
        rd_reg(1'b1, rd); chk("R5 resume flag", rd, 8'h01);
        chk("R6 clock off until ack", sie_clk_en_o, 1'b0);
        wr_reg(1'b1, 8'h04);
        chk("R6 clock on after ack", sie_clk_en_o, 1'b1);
        wr_reg(1'b1, 8'h01);

        // random mix: R4, R7, R8, R10
        exp_f = 4'h0;
        for (int i = 0; i < 24; i++) begin
            logic [7:0] en_v, mask;
            int ev;
            kick();
            ev = $urandom_range(0, 2);
            if (ev == 0) begin
                drive(1'b0, 1'b0, 6); drive(1'b1, 1'b0, 5);
                exp_f = exp_f | 4'h2;
            end else if (ev == 1) begin
                drive(1'b0, 1'b0, 1); drive(1'b1, 1'b0, 5);
            end
            en_v = 8'($urandom);
            wr_reg(1'b0, en_v);
            rd_reg(1'b0, rd); chk("R7 random enable readback", rd, {4'h0, en_v[3:0]});
            rd_reg(1'b1, rd); chk("R4 random flags", rd, {4'h0, exp_f});
            chk("R8 random irq", irq_o, model_irq(exp_f, en_v));
            mask = 8'($urandom);
            wr_reg(1'b1, mask);
            exp_f = model_w1c(exp_f, mask);
            rd_reg(1'b1, rd); chk("R10 random clear", rd, {4'h0, exp_f});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule